// File: doc/BRIEF.md
# Synchronizing Dataflow Register File

This block is the register file of a multithreaded core in which every entry pairs its data word with a synchronization state. An entry is EMPTY, PENDING, WAITING or FULL. It also records a linked list of threads suspended on it, held as head and tail thread identifiers, and a small descriptor of any load still outstanding for it. Integer and floating-point registers sit in two separate banks. A class bit plus an index selects the bank and the entry.

Three ports share the file. The first is a combinational read port. The second is a write port fed by the pipeline. The third is an asynchronous write port that memory, network and floating-point responders share. The asynchronous port carries a from-memory qualifier. Both write ports see the entry's old contents and decide in the same cycle whether the write is legal. Legal writes are committed together at the clock edge.

When a write fills a WAITING entry that has suspended threads, the block offers that thread list on a wake handshake. The write commits only if the wake is taken in the same cycle. Illegal writes are refused and reported on a registered error vector. Scheduling and the memory system stay outside the block.

Top module: `sync_regfile`

## Requirements
- R1: After reset every entry reads as state EMPTY, data 0, head and tail equal to the invalid thread ID (all ones), load size 0 and load tag 0. After reset `wake_valid` and `err_o` are 0.
- R2: State codes are EMPTY=0, PENDING=1, WAITING=2 and FULL=3. An accepted write (valid and ready high at a clock edge) stores state, data, head, tail, load size and load tag. The read port shows the new contents right after that edge.
- R3: A write of FULL to a WAITING entry whose head is not the invalid ID raises `wake_valid` in the same cycle, carrying the entry's old head and tail. The write is accepted only while `wake_ready` is high. Otherwise its ready is low and the entry is unchanged. FULL written over WAITING with an invalid head needs no wake.
- R4: Writing EMPTY over a WAITING entry is refused, and `err_o` bit 1 is set in the following cycle.
- R5: A write with state EMPTY or PENDING whose head is not the invalid ID is refused, and `err_o` bit 2 is set in the following cycle.
- R6: Consider an entry that is not FULL and has a nonzero load size. A write to it that sets FULL, or changes its load size or load tag, is accepted only from the asynchronous port with `aw_from_mem` high. Any other such write is refused, and `err_o` bit 3 is set in the following cycle. Pipeline writes never count as from memory. A write that keeps the descriptor and does not set FULL is allowed.
- R7: A write whose index is at or beyond the class size (integer 12 entries, float 6 entries by default) is refused, and `err_o` bit 0 is set in the following cycle. Reading such an index returns the R1 reset contents.
- R8: When both write ports address the same class and index in one cycle, the pipeline write proceeds, `aw_ready` is low and no error is raised.
- R9: Only one wake is offered per cycle. A pipeline wake has precedence. An asynchronous write that needs a wake while the pipeline presents one is refused that cycle, and is accepted with its own wake once the pipeline is idle.
- R10: Class bit 0 selects the integer bank and 1 the float bank. A write to one bank never changes the other.
- R11: `err_o` is registered. Each bit is the OR over both ports of the fault seen with valid high in the previous cycle, and it returns to 0 after a cycle with no faulty request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_cls | input | 1 | Read class (0 integer, 1 float) |
| rd_idx | input | 4 | Read index |
| rd_state | output | 2 | State of the read entry |
| rd_data | output | 16 | Data of the read entry |
| rd_head | output | 4 | Waiting-list head of the read entry |
| rd_tail | output | 4 | Waiting-list tail of the read entry |
| rd_ldsz | output | 2 | Pending-load size of the read entry |
| rd_ldtag | output | 4 | Pending-load tag of the read entry |
| pw_valid | input | 1 | Pipeline write request |
| pw_ready | output | 1 | Pipeline write accepted this cycle |
| pw_cls | input | 1 | Pipeline write class |
| pw_idx | input | 4 | Pipeline write index |
| pw_state | input | 2 | Pipeline write state |
| pw_data | input | 16 | Pipeline write data |
| pw_head | input | 4 | Pipeline write waiting-list head |
| pw_tail | input | 4 | Pipeline write waiting-list tail |
| pw_ldsz | input | 2 | Pipeline write load size |
| pw_ldtag | input | 4 | Pipeline write load tag |
| aw_valid | input | 1 | Asynchronous write request |
| aw_ready | output | 1 | Asynchronous write accepted this cycle |
| aw_from_mem | input | 1 | Asynchronous write comes from memory |
| aw_cls | input | 1 | Asynchronous write class |
| aw_idx | input | 4 | Asynchronous write index |
| aw_state | input | 2 | Asynchronous write state |
| aw_data | input | 16 | Asynchronous write data |
| aw_head | input | 4 | Asynchronous write waiting-list head |
| aw_tail | input | 4 | Asynchronous write waiting-list tail |
| aw_ldsz | input | 2 | Asynchronous write load size |
| aw_ldtag | input | 4 | Asynchronous write load tag |
| wake_valid | output | 1 | Wake request for a thread list |
| wake_ready | input | 1 | Wake request taken |
| wake_head | output | 4 | Head of the list to wake |
| wake_tail | output | 4 | Tail of the list to wake |
| err_o | output | 4 | Registered fault flags: bit 0 range, bit 1 reset of waiting, bit 2 bad head, bit 3 load protection |

## Verification
The bench targets the following corner cases:
- **Refused FULL write while the wake is not taken.** A design that committed anyway would lose the suspended threads.
- **FULL over WAITING with an empty list.** A design that stalled here would hang on a wake nobody needs.
- **Load-protected entry.** The bench writes it from the pipeline, from a non-memory responder and from memory. Only the last may fill it; an unguarded design would let a stale value overwrite an in-flight load.
- **Same-address collision.** A design that let the asynchronous port win would overwrite the pipeline result.
- **Contention for the single wake channel.** A design without precedence would drop one of the lists.
- **Out-of-range indices and bank separation.** A sliced index that aliased into another entry would corrupt it.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int TID_W   = 4;
  localparam int DATA_W  = 16;
  localparam int LDSZ_W  = 2;
  localparam int LDTAG_W = 4;
  localparam int ERR_W   = 4;

  localparam int ERR_RANGE = 0;
  localparam int ERR_RSTW  = 1;
  localparam int ERR_HEAD  = 2;
  localparam int ERR_LOAD  = 3;

  typedef enum logic [1:0] {
    ST_EMPTY   = 2'd0,
    ST_PENDING = 2'd1,
    ST_WAITING = 2'd2,
    ST_FULL    = 2'd3
  } st_e;

  typedef logic [TID_W-1:0] tid_t;
  localparam tid_t TID_NONE = '1;

  typedef struct packed {
    st_e                st;
    logic [DATA_W-1:0]  data;
    tid_t               head;
    tid_t               tail;
    logic [LDSZ_W-1:0]  ldsz;
    logic [LDTAG_W-1:0] ldtag;
  } ent_t;

  function automatic ent_t ent_reset();
    ent_t e;
    e.st    = ST_EMPTY;
    e.data  = '0;
    e.head  = TID_NONE;
    e.tail  = TID_NONE;
    e.ldsz  = '0;
    e.ldtag = '0;
    return e;
  endfunction

  // Fault vector for one write against the entry's old contents.
  function automatic logic [ERR_W-1:0] write_faults(ent_t old_e, ent_t new_e,
                                                    logic from_mem, logic in_range);
    logic [ERR_W-1:0] f;
    logic desc_change;
    f = '0;
    desc_change = (new_e.ldsz != old_e.ldsz) || (new_e.ldtag != old_e.ldtag);
    f[ERR_RANGE] = !in_range;
    f[ERR_RSTW]  = (old_e.st == ST_WAITING) && (new_e.st == ST_EMPTY);
    f[ERR_HEAD]  = ((new_e.st == ST_EMPTY) || (new_e.st == ST_PENDING)) &&
                   (new_e.head != TID_NONE);
    f[ERR_LOAD]  = (old_e.st != ST_FULL) && (old_e.ldsz != '0) && !from_mem &&
                   ((new_e.st == ST_FULL) || desc_change);
    return f;
  endfunction

  function automatic logic wake_needed(ent_t old_e, ent_t new_e);
    return (new_e.st == ST_FULL) && (old_e.st == ST_WAITING) &&
           (old_e.head != TID_NONE);
  endfunction
endpackage

// File: rtl/srf_bank.sv
module srf_bank
  import srf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] r_idx,
  output ent_t             r_ent,
  input  logic [IDX_W-1:0] p_idx,
  output ent_t             p_ent,
  output logic             p_ok,
  input  logic [IDX_W-1:0] a_idx,
  output ent_t             a_ent,
  output logic             a_ok,
  input  logic             p_we,
  input  ent_t             p_wr,
  input  logic             a_we,
  input  ent_t             a_wr
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(DEPTH);

  ent_t mem [DEPTH];
  logic r_ok;

  assign r_ok = ({1'b0, r_idx} < LIMIT);
  assign p_ok = ({1'b0, p_idx} < LIMIT);
  assign a_ok = ({1'b0, a_idx} < LIMIT);

  assign r_ent = r_ok ? mem[r_idx[AW-1:0]] : ent_reset();
  assign p_ent = p_ok ? mem[p_idx[AW-1:0]] : ent_reset();
  assign a_ent = a_ok ? mem[a_idx[AW-1:0]] : ent_reset();

  // Both ports commit at the same edge; the top never enables both on one entry.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ent_reset();
    end else begin
      if (p_we && p_ok) mem[p_idx[AW-1:0]] <= p_wr;
      if (a_we && a_ok) mem[a_idx[AW-1:0]] <= a_wr;
    end
  end
endmodule

// File: rtl/srf_wcheck.sv
module srf_wcheck
  import srf_pkg::*;
(
  input  ent_t             old_e,
  input  ent_t             new_e,
  input  logic             from_mem,
  input  logic             in_range,
  output logic [ERR_W-1:0] faults,
  output logic             wake_need
);
  assign faults    = write_faults(old_e, new_e, from_mem, in_range);
  assign wake_need = in_range && wake_needed(old_e, new_e);
endmodule

// File: rtl/srf_wake_arb.sv
module srf_wake_arb
  import srf_pkg::*;
(
  input  logic pw_valid,
  input  logic pw_bad,
  input  logic pw_need,
  input  tid_t pw_head,
  input  tid_t pw_tail,
  input  logic aw_valid,
  input  logic aw_bad,
  input  logic aw_need,
  input  tid_t aw_head,
  input  tid_t aw_tail,
  input  logic collide,
  input  logic wake_ready,
  output logic pw_ready,
  output logic aw_ready,
  output logic wake_valid,
  output tid_t wake_head,
  output tid_t wake_tail
);
  logic pw_wreq, aw_wreq;

  assign pw_wreq  = pw_valid && !pw_bad && pw_need;
  assign aw_wreq  = aw_valid && !aw_bad && !collide && aw_need && !pw_wreq;

  assign pw_ready = !pw_bad && (!pw_need || wake_ready);
  assign aw_ready = !aw_bad && !collide && (!aw_need || (wake_ready && !pw_wreq));

  assign wake_valid = pw_wreq || aw_wreq;
  assign wake_head  = pw_wreq ? pw_head : aw_head;
  assign wake_tail  = pw_wreq ? pw_tail : aw_tail;
endmodule

// File: rtl/sync_regfile.sv
module sync_regfile
  import srf_pkg::*;
#(
  parameter int INT_REGS = 12,
  parameter int FLT_REGS = 6,
  parameter int IDX_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_cls,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [1:0]         rd_state,
  output logic [DATA_W-1:0]  rd_data,
  output logic [TID_W-1:0]   rd_head,
  output logic [TID_W-1:0]   rd_tail,
  output logic [LDSZ_W-1:0]  rd_ldsz,
  output logic [LDTAG_W-1:0] rd_ldtag,
  input  logic               pw_valid,
  output logic               pw_ready,
  input  logic               pw_cls,
  input  logic [IDX_W-1:0]   pw_idx,
  input  logic [1:0]         pw_state,
  input  logic [DATA_W-1:0]  pw_data,
  input  logic [TID_W-1:0]   pw_head,
  input  logic [TID_W-1:0]   pw_tail,
  input  logic [LDSZ_W-1:0]  pw_ldsz,
  input  logic [LDTAG_W-1:0] pw_ldtag,
  input  logic               aw_valid,
  output logic               aw_ready,
  input  logic               aw_from_mem,
  input  logic               aw_cls,
  input  logic [IDX_W-1:0]   aw_idx,
  input  logic [1:0]         aw_state,
  input  logic [DATA_W-1:0]  aw_data,
  input  logic [TID_W-1:0]   aw_head,
  input  logic [TID_W-1:0]   aw_tail,
  input  logic [LDSZ_W-1:0]  aw_ldsz,
  input  logic [LDTAG_W-1:0] aw_ldtag,
  output logic               wake_valid,
  input  logic               wake_ready,
  output logic [TID_W-1:0]   wake_head,
  output logic [TID_W-1:0]   wake_tail,
  output logic [ERR_W-1:0]   err_o
);
  localparam int NCLS = 2;

  ent_t rd_c [NCLS];
  ent_t pw_old_c [NCLS];
  ent_t aw_old_c [NCLS];
  logic pw_ok_c [NCLS];
  logic aw_ok_c [NCLS];

  ent_t pw_new, aw_new, rd_e, pw_old, aw_old;
  logic pw_in_range, aw_in_range;
  logic [ERR_W-1:0] pw_err, aw_err;
  logic pw_wake_need, aw_wake_need;
  logic collide, pw_commit, aw_commit;
  logic [ERR_W-1:0] err_q;

  assign pw_new = '{st: st_e'(pw_state), data: pw_data, head: pw_head,
                    tail: pw_tail, ldsz: pw_ldsz, ldtag: pw_ldtag};
  assign aw_new = '{st: st_e'(aw_state), data: aw_data, head: aw_head,
                    tail: aw_tail, ldsz: aw_ldsz, ldtag: aw_ldtag};

  for (genvar c = 0; c < NCLS; c++) begin : g_bank
    localparam int DEPTH = (c == 0) ? INT_REGS : FLT_REGS;
    srf_bank #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .r_idx (rd_idx),
      .r_ent (rd_c[c]),
      .p_idx (pw_idx),
      .p_ent (pw_old_c[c]),
      .p_ok  (pw_ok_c[c]),
      .a_idx (aw_idx),
      .a_ent (aw_old_c[c]),
      .a_ok  (aw_ok_c[c]),
      .p_we  (pw_commit && (pw_cls == 1'(c))),
      .p_wr  (pw_new),
      .a_we  (aw_commit && (aw_cls == 1'(c))),
      .a_wr  (aw_new)
    );
  end

  assign rd_e        = rd_c[rd_cls];
  assign pw_old      = pw_old_c[pw_cls];
  assign aw_old      = aw_old_c[aw_cls];
  assign pw_in_range = pw_ok_c[pw_cls];
  assign aw_in_range = aw_ok_c[aw_cls];

  srf_wcheck u_pw_chk (
    .old_e     (pw_old),
    .new_e     (pw_new),
    .from_mem  (1'b0),
    .in_range  (pw_in_range),
    .faults    (pw_err),
    .wake_need (pw_wake_need)
  );

  srf_wcheck u_aw_chk (
    .old_e     (aw_old),
    .new_e     (aw_new),
    .from_mem  (aw_from_mem),
    .in_range  (aw_in_range),
    .faults    (aw_err),
    .wake_need (aw_wake_need)
  );

  assign collide = pw_valid && aw_valid && (pw_cls == aw_cls) && (pw_idx == aw_idx);

  srf_wake_arb u_arb (
    .pw_valid   (pw_valid),
    .pw_bad     (|pw_err),
    .pw_need    (pw_wake_need),
    .pw_head    (pw_old.head),
    .pw_tail    (pw_old.tail),
    .aw_valid   (aw_valid),
    .aw_bad     (|aw_err),
    .aw_need    (aw_wake_need),
    .aw_head    (aw_old.head),
    .aw_tail    (aw_old.tail),
    .collide    (collide),
    .wake_ready (wake_ready),
    .pw_ready   (pw_ready),
    .aw_ready   (aw_ready),
    .wake_valid (wake_valid),
    .wake_head  (wake_head),
    .wake_tail  (wake_tail)
  );

  assign pw_commit = pw_valid && pw_ready;
  assign aw_commit = aw_valid && aw_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= (pw_valid ? pw_err : '0) | (aw_valid ? aw_err : '0);
  end

  assign err_o    = err_q;
  assign rd_state = rd_e.st;
  assign rd_data  = rd_e.data;
  assign rd_head  = rd_e.head;
  assign rd_tail  = rd_e.tail;
  assign rd_ldsz  = rd_e.ldsz;
  assign rd_ldtag = rd_e.ldtag;
endmodule

// File: rtl/sync_regfile_chk.sv
module sync_regfile_chk
  import srf_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             pw_valid,
  input logic             pw_ready,
  input logic             pw_cls,
  input logic [3:0]       pw_idx,
  input logic [1:0]       pw_state,
  input logic [TID_W-1:0] pw_head,
  input logic             aw_valid,
  input logic             aw_ready,
  input logic             aw_cls,
  input logic [3:0]       aw_idx,
  input logic             wake_valid,
  input logic             wake_ready,
  input logic [TID_W-1:0] wake_head,
  input logic [ERR_W-1:0] err_o,
  input logic             pw_wake_need,
  input logic             aw_wake_need,
  input logic             pw_in_range,
  input logic [1:0]       pw_old_state,
  input logic [TID_W-1:0] pw_old_head,
  input logic [ERR_W-1:0] pw_err
);
  // R3: no commit while the needed wake is not taken
  a_r3_hold_without_wake: assert property (@(posedge clk) disable iff (!rst_n)
    pw_valid && pw_wake_need && !wake_ready |-> !pw_ready);

  // R3: the wake carries the old head of the entry being filled
  a_r3_wake_offered: assert property (@(posedge clk) disable iff (!rst_n)
    pw_valid && pw_wake_need && (pw_err == '0) |-> wake_valid && (wake_head == pw_old_head));

  // R3: a wake is only offered for a live request
  a_r3_wake_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> pw_valid || aw_valid);

  // R4: emptying a waiting entry is flagged next cycle
  a_r4_reset_waiting_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    pw_valid && pw_in_range && (pw_old_state == 2'd2) && (pw_state == 2'd0) |=> err_o[ERR_RSTW]);

  // R5: non-full writes must carry no list head
  a_r5_head_refused: assert property (@(posedge clk) disable iff (!rst_n)
    pw_valid && (pw_state <= 2'd1) && (pw_head != TID_NONE) |-> !pw_ready);

  // R7: out-of-range index never accepted
  a_r7_range_refused: assert property (@(posedge clk) disable iff (!rst_n)
    pw_valid && !pw_in_range |-> !pw_ready);

  // R8: same-address collision refuses the asynchronous port
  a_r8_collision: assert property (@(posedge clk) disable iff (!rst_n)
    pw_valid && aw_valid && (pw_cls == aw_cls) && (pw_idx == aw_idx) |-> !aw_ready);

  // R9: at most one wake per cycle, pipeline first
  a_r9_single_wake: assert property (@(posedge clk) disable iff (!rst_n)
    pw_valid && pw_ready && pw_wake_need && aw_valid && aw_wake_need |-> !aw_ready);

  // R11: quiet cycle leaves no fault behind
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pw_valid && !aw_valid |=> (err_o == '0));
endmodule

bind sync_regfile sync_regfile_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pw_valid     (pw_valid),
  .pw_ready     (pw_ready),
  .pw_cls       (pw_cls),
  .pw_idx       (pw_idx),
  .pw_state     (pw_state),
  .pw_head      (pw_head),
  .aw_valid     (aw_valid),
  .aw_ready     (aw_ready),
  .aw_cls       (aw_cls),
  .aw_idx       (aw_idx),
  .wake_valid   (wake_valid),
  .wake_ready   (wake_ready),
  .wake_head    (wake_head),
  .err_o        (err_o),
  .pw_wake_need (pw_wake_need),
  .aw_wake_need (aw_wake_need),
  .pw_in_range  (pw_in_range),
  .pw_old_state (pw_old.st),
  .pw_old_head  (pw_old.head),
  .pw_err       (pw_err)
);

// File: tb/sync_regfile_bench.sv
module sync_regfile_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rd_cls; logic [3:0] rd_idx;
  logic [1:0] rd_state; logic [15:0] rd_data; logic [3:0] rd_head, rd_tail, rd_ldtag; logic [1:0] rd_ldsz;
  logic pw_valid, pw_ready, pw_cls; logic [3:0] pw_idx; logic [1:0] pw_state; logic [15:0] pw_data;
  logic [3:0] pw_head, pw_tail, pw_ldtag; logic [1:0] pw_ldsz;
  logic aw_valid, aw_ready, aw_from_mem, aw_cls; logic [3:0] aw_idx; logic [1:0] aw_state; logic [15:0] aw_data;
  logic [3:0] aw_head, aw_tail, aw_ldtag; logic [1:0] aw_ldsz;
  logic wake_valid, wake_ready; logic [3:0] wake_head, wake_tail; logic [3:0] err_o;

  sync_regfile u_sync_regfile (.*);

  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    pw_valid = 0; pw_cls = 0; pw_idx = 0; pw_state = 0; pw_data = 0;
    pw_head = 4'hF; pw_tail = 4'hF; pw_ldsz = 0; pw_ldtag = 0;
    aw_valid = 0; aw_from_mem = 0; aw_cls = 0; aw_idx = 0; aw_state = 0; aw_data = 0;
    aw_head = 4'hF; aw_tail = 4'hF; aw_ldsz = 0; aw_ldtag = 0;
    wake_ready = 1;
  endtask

  task automatic set_pw(input logic c, input logic [3:0] i, input logic [1:0] s, input logic [15:0] d,
                        input logic [3:0] h, input logic [3:0] t, input logic [1:0] lz, input logic [3:0] lt);
    pw_valid = 1; pw_cls = c; pw_idx = i; pw_state = s; pw_data = d;
    pw_head = h; pw_tail = t; pw_ldsz = lz; pw_ldtag = lt;
  endtask

  task automatic set_aw(input logic fm, input logic c, input logic [3:0] i, input logic [1:0] s,
                        input logic [15:0] d, input logic [3:0] h, input logic [3:0] t,
                        input logic [1:0] lz, input logic [3:0] lt);
    aw_valid = 1; aw_from_mem = fm; aw_cls = c; aw_idx = i; aw_state = s; aw_data = d;
    aw_head = h; aw_tail = t; aw_ldsz = lz; aw_ldtag = lt;
  endtask

  task automatic look(input logic c, input logic [3:0] i);
    rd_cls = c; rd_idx = i;
  endtask

  // One pipeline write per row; the read port watches the same entry.
  typedef struct packed {
    logic [3:0]  req;
    logic        cls;
    logic [3:0]  idx;
    logic [1:0]  st;
    logic [15:0] data;
    logic [3:0]  head;
    logic [3:0]  tail;
    logic [1:0]  ldsz;
    logic [3:0]  ldtag;
    logic        wrdy;
    logic        e_rdy;
    logic        e_wake;
    logic [3:0]  e_wh;
    logic [3:0]  e_wt;
    logic [3:0]  e_err;
    logic [1:0]  e_st;
    logic [15:0] e_data;
  } row_t;

  localparam int NROWS = 17;
  localparam row_t ROWS [NROWS] = '{
    // R2: plain writes land
    '{4'd2, 1'b0, 4'd3, 2'd1, 16'h0000, 4'hF, 4'hF, 2'd0, 4'd0, 1'b1, 1'b1, 1'b0, 4'h0, 4'h0, 4'h0, 2'd1, 16'h0000},
    '{4'd2, 1'b0, 4'd3, 2'd2, 16'h0000, 4'h2, 4'h5, 2'd0, 4'd0, 1'b1, 1'b1, 1'b0, 4'h0, 4'h0, 4'h0, 2'd2, 16'h0000},
    // R3: fill WAITING with wake refused, then taken
    '{4'd3, 1'b0, 4'd3, 2'd3, 16'hABCD, 4'hF, 4'hF, 2'd0, 4'd0, 1'b0, 1'b0, 1'b1, 4'h2, 4'h5, 4'h0, 2'd2, 16'h0000},
    '{4'd3, 1'b0, 4'd3, 2'd3, 16'hABCD, 4'hF, 4'hF, 2'd0, 4'd0, 1'b1, 1'b1, 1'b1, 4'h2, 4'h5, 4'h0, 2'd3, 16'hABCD},
    '{4'd2, 1'b0, 4'd3, 2'd0, 16'h0000, 4'hF, 4'hF, 2'd0, 4'd0, 1'b1, 1'b1, 1'b0, 4'h0, 4'h0, 4'h0, 2'd0, 16'h0000},
    // R4: EMPTY over WAITING
    '{4'd4, 1'b0, 4'd4, 2'd2, 16'h0000, 4'h1, 4'h1, 2'd0, 4'd0, 1'b1, 1'b1, 1'b0, 4'h0, 4'h0, 4'h0, 2'd2, 16'h0000},
    '{4'd4, 1'b0, 4'd4, 2'd0, 16'h0000, 4'hF, 4'hF, 2'd0, 4'd0, 1'b1, 1'b0, 1'b0, 4'h0, 4'h0, 4'h2, 2'd2, 16'h0000},
    // R5: PENDING with a head
    '{4'd5, 1'b0, 4'd5, 2'd1, 16'h0000, 4'h3, 4'h3, 2'd0, 4'd0, 1'b1, 1'b0, 1'b0, 4'h0, 4'h0, 4'h4, 2'd0, 16'h0000},
    // R7: out of range integer index 12
    '{4'd7, 1'b0, 4'd12, 2'd3, 16'h0099, 4'hF, 4'hF, 2'd0, 4'd0, 1'b1, 1'b0, 1'b0, 4'h0, 4'h0, 4'h1, 2'd0, 16'h0000},
    // R10: float bank write
    '{4'd10, 1'b1, 4'd5, 2'd3, 16'h1234, 4'hF, 4'hF, 2'd0, 4'd0, 1'b1, 1'b1, 1'b0, 4'h0, 4'h0, 4'h0, 2'd3, 16'h1234},
    // R7: out of range float index 6
    '{4'd7, 1'b1, 4'd6, 2'd3, 16'h0001, 4'hF, 4'hF, 2'd0, 4'd0, 1'b1, 1'b0, 1'b0, 4'h0, 4'h0, 4'h1, 2'd0, 16'h0000},
    // R6: load-pending entry vs pipeline writes
    '{4'd6, 1'b0, 4'd7, 2'd1, 16'h0000, 4'hF, 4'hF, 2'd2, 4'd9, 1'b1, 1'b1, 1'b0, 4'h0, 4'h0, 4'h0, 2'd1, 16'h0000},
    '{4'd6, 1'b0, 4'd7, 2'd3, 16'h00EE, 4'hF, 4'hF, 2'd2, 4'd9, 1'b1, 1'b0, 1'b0, 4'h0, 4'h0, 4'h8, 2'd1, 16'h0000},
    '{4'd6, 1'b0, 4'd7, 2'd1, 16'h0000, 4'hF, 4'hF, 2'd2, 4'd9, 1'b1, 1'b1, 1'b0, 4'h0, 4'h0, 4'h0, 2'd1, 16'h0000},
    '{4'd6, 1'b0, 4'd7, 2'd1, 16'h0000, 4'hF, 4'hF, 2'd1, 4'd9, 1'b1, 1'b0, 1'b0, 4'h0, 4'h0, 4'h8, 2'd1, 16'h0000},
    // R3: FULL over WAITING with no list needs no wake
    '{4'd3, 1'b0, 4'd8, 2'd2, 16'h0000, 4'hF, 4'hF, 2'd0, 4'd0, 1'b1, 1'b1, 1'b0, 4'h0, 4'h0, 4'h0, 2'd2, 16'h0000},
    '{4'd3, 1'b0, 4'd8, 2'd3, 16'h0055, 4'hF, 4'hF, 2'd0, 4'd0, 1'b0, 1'b1, 1'b0, 4'h0, 4'h0, 4'h0, 2'd3, 16'h0055}
  };

  initial begin
    idle();
    look(0, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();

    // R1: reset contents and quiet outputs
    look(0, 0); #1;
    chk("R1 state", rd_state, 0);
    chk("R1 data", rd_data, 0);
    chk("R1 head", rd_head, 4'hF);
    chk("R1 tail", rd_tail, 4'hF);
    chk("R1 ldsz", rd_ldsz, 0);
    chk("R1 ldtag", rd_ldtag, 0);
    chk("R1 wake", wake_valid, 0);
    chk("R1 err", err_o, 0);
    look(1, 5); #1;
    chk("R1 float state", rd_state, 0);

    for (int k = 0; k < NROWS; k++) begin
      row_t r;
      r = ROWS[k];
      tick();
      set_pw(r.cls, r.idx, r.st, r.data, r.head, r.tail, r.ldsz, r.ldtag);
      wake_ready = r.wrdy;
      look(r.cls, r.idx);
      #1;
      chk($sformatf("R%0d row%0d ready", r.req, k), pw_ready, r.e_rdy);
      chk($sformatf("R%0d row%0d wake", r.req, k), wake_valid, r.e_wake);
      if (r.e_wake) begin
        chk($sformatf("R%0d row%0d wake_head", r.req, k), wake_head, r.e_wh);
        chk($sformatf("R%0d row%0d wake_tail", r.req, k), wake_tail, r.e_wt);
      end
      tick();
      chk($sformatf("R%0d row%0d err", r.req, k), err_o, r.e_err);
      chk($sformatf("R%0d row%0d state", r.req, k), rd_state, r.e_st);
      chk($sformatf("R%0d row%0d data", r.req, k), rd_data, r.e_data);
      idle();
    end

    // R11: fault clears after a quiet cycle
    tick();
    chk("R11 err cleared", err_o, 0);

    // R10: banks independent
    look(0, 5); #1;
    chk("R10 int idx5 untouched", rd_state, 0);
    look(1, 3); #1;
    chk("R10 float idx3 untouched", rd_state, 0);
    look(1, 12); #1;
    chk("R7 out-of-range read", rd_state, 0);
    chk("R7 out-of-range read head", rd_head, 4'hF);

    // R6: asynchronous port with and without memory qualifier
    set_pw(0, 9, 1, 0, 4'hF, 4'hF, 1, 3);
    tick(); idle();
    set_aw(0, 0, 9, 3, 16'h0066, 4'hF, 4'hF, 0, 0);
    look(0, 9); #1;
    chk("R6 non-memory fill refused", aw_ready, 0);
    tick();
    chk("R6 non-memory err", err_o, 4'h8);
    chk("R6 still pending", rd_state, 1);
    set_aw(1, 0, 9, 3, 16'h0077, 4'hF, 4'hF, 0, 0); #1;
    chk("R6 memory fill ready", aw_ready, 1);
    tick();
    chk("R6 memory fill state", rd_state, 3);
    chk("R6 memory fill data", rd_data, 16'h0077);
    chk("R6 memory fill no err", err_o, 0);
    idle();

    // R8: same-address collision
    set_pw(0, 10, 3, 16'h0011, 4'hF, 4'hF, 0, 0);
    set_aw(0, 0, 10, 3, 16'h0022, 4'hF, 4'hF, 0, 0);
    look(0, 10); #1;
    chk("R8 pipeline ready", pw_ready, 1);
    chk("R8 async refused", aw_ready, 0);
    tick();
    chk("R8 pipeline data wins", rd_data, 16'h0011);
    chk("R8 no error", err_o, 0);
    idle();

    // R9: one wake channel, pipeline first
    set_pw(0, 11, 2, 0, 4'h4, 4'h6, 0, 0);
    tick();
    set_pw(1, 2, 2, 0, 4'h7, 4'h8, 0, 0);
    tick(); idle();
    set_pw(0, 11, 3, 16'h0A0A, 4'hF, 4'hF, 0, 0);
    set_aw(0, 1, 2, 3, 16'h0B0B, 4'hF, 4'hF, 0, 0);
    look(1, 2); #1;
    chk("R9 wake offered", wake_valid, 1);
    chk("R9 pipeline head first", wake_head, 4'h4);
    chk("R9 pipeline accepted", pw_ready, 1);
    chk("R9 async deferred", aw_ready, 0);
    tick();
    chk("R9 async entry unchanged", rd_state, 2);
    pw_valid = 0; #1;
    chk("R9 async wake head", wake_head, 4'h7);
    chk("R9 async wake tail", wake_tail, 4'h8);
    chk("R9 async ready", aw_ready, 1);
    tick();
    chk("R9 async filled", rd_state, 3);
    chk("R9 async data", rd_data, 16'h0B0B);
    idle();

    // R11: faults from both ports merge
    set_pw(0, 0, 0, 0, 4'h3, 4'hF, 0, 0);
    set_aw(0, 0, 13, 3, 0, 4'hF, 4'hF, 0, 0);
    tick(); idle();
    chk("R11 merged faults", err_o, 4'h5);
    tick();
    chk("R11 merged faults cleared", err_o, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule